// File: doc/BRIEF.md
# CAN Bus Wake-Up Pattern Detector

This block runs while the transceiver sits in a low-power mode. It watches a sampled bus level, where 1 means dominant and 0 means recessive, and looks for a three-phase remote wake sequence: a qualified dominant phase, then a qualified recessive phase, then a second qualified dominant phase. A level counts as qualified only when it has held longer than a programmable filter time. Bus activity that is too short to qualify never advances the sequence and never discards progress already made. The whole sequence must complete inside a timeout window, so a stuck bus or sporadic noise cannot produce a wake.

When the sequence completes, the block latches a wake request. It signals the request on an active-low receive-data output, but only while the I/O supply is reported valid. The request stays latched until the surrounding mode controller pulses a clear. Dropping the enable input, which means the block has left low-power mode, returns every counter and state to idle.

Top module: `can_wake_detector`

## Requirements
- R1: A bus level is qualified only after the raw input has shown that level on FILTER_CYCLES+1 consecutive rising clock edges. A run of FILTER_CYCLES edges never qualifies. Each change of level restarts the run count.
- R2: A wake is recognised only for the order dominant, recessive, dominant (input value 1, then 0, then 1), each phase qualified. The first qualified dominant starts a pattern.
- R3: While the detector waits for the qualified recessive, or for the second qualified dominant, bus runs too short to qualify leave the partial pattern intact.
- R4: wake_req rises on the (FILTER_CYCLES+4)-th rising edge counted from the first edge that samples the second dominant phase. That count includes a two-stage input synchroniser.
- R5: rxd_n is 0 exactly when wake_req is 1 and vio_ok is 1. A wake recognised while vio_ok is 0 is kept, and rxd_n falls as soon as vio_ok becomes 1.
- R6: A pattern that has not completed within TIMEOUT_CYCLES cycles of its first dominant phase qualifying is dropped without a wake.
- R7: If the bus level is dominant when the timeout expires, a qualified recessive phase must occur before a new first dominant phase is accepted.
- R8: wake_req stays 1 until wake_clear is pulsed. A clear pulse drops wake_req and abandons any partial pattern.
- R9: While enable is 0, wake_req stays 0, any partial pattern and the filter run count are discarded, and bus activity is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High while low-power mode is active; low resets detection |
| bus_dom_raw | input | 1 | Asynchronous bus level, 1 = dominant, 0 = recessive |
| vio_ok | input | 1 | I/O supply valid flag |
| wake_clear | input | 1 | Synchronous pulse that clears the latched wake and returns to idle |
| wake_req | output | 1 | Latched wake request |
| rxd_n | output | 1 | Active-low wake indication on receive data |

## Verification
The assertions assume that reset is applied before the first check. They also assume that enable, wake_clear and vio_ok change away from the active clock edge and behave as ordinary synchronous levels. Only bus_dom_raw may be asynchronous, and it reaches the logic only through the synchroniser. The stimulus drives every input at the falling edge. It holds each bus level for a whole number of cycles, and it keeps the phase lengths either clearly above or exactly at the filter boundary and clearly inside or clearly beyond the timeout window. This way every expected result falls on a known clock edge.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REC,
    ST_WAIT_DOM,
    ST_WOKE,
    ST_REARM
  } wake_st_t;

  // A run qualifies once its length exceeds the filter time.
  function automatic logic run_filtered(input int run_len, input int filt);
    return run_len > filt;
  endfunction

  // Window ends on the last cycle counted from zero.
  function automatic logic window_done(input int elapsed, input int limit);
    return (elapsed + 1) >= limit;
  endfunction

endpackage

// File: rtl/cwd_sync.sv
module cwd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cwd_run_filter.sv
module cwd_run_filter
  import can_wake_pkg::*;
#(
  parameter int FILTER_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic lvl_in,
  output logic lvl_q,
  output logic qual
);
  localparam int CW = $clog2(FILTER_CYCLES + 2);
  localparam logic [CW-1:0] SAT = CW'(FILTER_CYCLES + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      run_cnt <= '0;
    end else if (!enable) begin
      lvl_q   <= 1'b0;
      run_cnt <= '0;
    end else if (lvl_in != lvl_q) begin
      lvl_q   <= lvl_in;
      run_cnt <= CW'(1);
    end else if (run_cnt != SAT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign qual = run_filtered(32'(run_cnt), FILTER_CYCLES);
endmodule

// File: rtl/cwd_window_timer.sv
module cwd_window_timer
  import can_wake_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [TW-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         elapsed <= '0;
    else if (!run)      elapsed <= '0;
    else if (!expired)  elapsed <= elapsed + 1'b1;
  end

  assign expired = run && window_done(32'(elapsed), TIMEOUT_CYCLES);
endmodule

// File: rtl/can_wake_detector.sv
module can_wake_detector
  import can_wake_pkg::*;
#(
  parameter int FILTER_CYCLES  = 8,
  parameter int TIMEOUT_CYCLES = 2000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bus_dom_raw,
  input  logic vio_ok,
  input  logic wake_clear,
  output logic wake_req,
  output logic rxd_n
);
  wake_st_t st;
  logic bus_sync;
  logic bus_lvl;
  logic qual;
  logic qual_dom;
  logic qual_rec;
  logic pattern_busy;
  logic rearm_pending;
  logic tmo_evt;
  logic recog_evt;
  logic wake_q;

  cwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_dom_raw), .q(bus_sync)
  );

  cwd_run_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .lvl_in(bus_sync), .lvl_q(bus_lvl), .qual(qual)
  );

  cwd_window_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(pattern_busy), .expired(tmo_evt)
  );

  assign qual_dom      = qual & bus_lvl;
  assign qual_rec      = qual & ~bus_lvl;
  assign pattern_busy  = (st == ST_WAIT_REC) || (st == ST_WAIT_DOM);
  assign rearm_pending = (st == ST_REARM);
  assign recog_evt     = (st == ST_WAIT_DOM) && qual_dom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wake_q <= 1'b0;
    end else if (!enable || wake_clear) begin
      st     <= ST_IDLE;
      wake_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE:     if (qual_dom) st <= ST_WAIT_REC;
        ST_WAIT_REC: begin
          if (tmo_evt)       st <= bus_lvl ? ST_REARM : ST_IDLE;
          else if (qual_rec) st <= ST_WAIT_DOM;
        end
        ST_WAIT_DOM: begin
          if (recog_evt) begin
            st     <= ST_WOKE;
            wake_q <= 1'b1;
          end else if (tmo_evt) begin
            st <= bus_lvl ? ST_REARM : ST_IDLE;
          end
        end
        ST_WOKE:     st <= ST_WOKE;
        ST_REARM:    if (qual_rec) st <= ST_IDLE;
        default:     st <= ST_IDLE;
      endcase
    end
  end

  assign wake_req = wake_q;
  assign rxd_n    = ~(wake_q & vio_ok);
endmodule

// File: rtl/can_wake_detector_chk.sv
module can_wake_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic wake_clear,
  input logic wake_req,
  input logic qual_dom,
  input logic pattern_busy,
  input logic rearm_pending,
  input logic tmo_evt,
  input logic recog_evt,
  input logic bus_lvl
);
  a_r2_start_on_dom: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pattern_busy) |-> $past(qual_dom));

  a_r4_wake_from_qual: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(qual_dom));

  a_r6_timeout_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && enable && !wake_clear) |=> !pattern_busy);

  a_r7_rearm_on_dom: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && enable && !wake_clear && !recog_evt && bus_lvl) |=> rearm_pending);

  a_r8_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && enable && !wake_clear) |=> wake_req);

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!wake_req && !pattern_busy));
endmodule

bind can_wake_detector can_wake_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wake_clear(wake_clear),
  .wake_req(wake_req), .qual_dom(qual_dom), .pattern_busy(pattern_busy),
  .rearm_pending(rearm_pending), .tmo_evt(tmo_evt), .recog_evt(recog_evt),
  .bus_lvl(bus_lvl)
);

// File: tb/can_wake_detector_bench.sv
`timescale 1ns/1ps
module can_wake_detector_bench;
  localparam int F = 4;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic bus = 1'b0;
  logic vio = 1'b1;
  logic clr = 1'b0;
  logic wake_req;
  logic rxd_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_wake_detector #(.FILTER_CYCLES(F), .TIMEOUT_CYCLES(T)) u_can_wake_detector (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bus_dom_raw(bus),
    .vio_ok(vio), .wake_clear(clr), .wake_req(wake_req), .rxd_n(rxd_n)
  );

  typedef struct packed {
    logic       c;
    logic       dom;
    logic [7:0] len;
    logic       v;
    logic       chk;
    logic       wk;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,8'd10,1'b1,1'b1,1'b0},  // 0  idle, R2
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 1  R2 first dominant
    '{1'b0,1'b0,8'd5, 1'b1,1'b0,1'b0},  // 2  recessive
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 3  second dominant
    '{1'b0,1'b0,8'd6, 1'b1,1'b1,1'b1},  // 4  R2 wake seen
    '{1'b0,1'b0,8'd30,1'b1,1'b1,1'b1},  // 5  R8 held
    '{1'b1,1'b0,8'd6, 1'b1,1'b1,1'b0},  // 6  R8 cleared
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 7  R3 first dominant
    '{1'b0,1'b0,8'd2, 1'b1,1'b0,1'b0},  // 8  short
    '{1'b0,1'b1,8'd3, 1'b1,1'b0,1'b0},  // 9  short
    '{1'b0,1'b0,8'd5, 1'b1,1'b0,1'b0},  // 10 qualified recessive
    '{1'b0,1'b1,8'd2, 1'b1,1'b0,1'b0},  // 11 short
    '{1'b0,1'b0,8'd3, 1'b1,1'b0,1'b0},  // 12 short
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 13 second dominant
    '{1'b0,1'b0,8'd6, 1'b1,1'b1,1'b1},  // 14 R3 wake kept progress
    '{1'b1,1'b0,8'd6, 1'b1,1'b1,1'b0},  // 15 clear
    '{1'b0,1'b1,8'd4, 1'b1,1'b0,1'b0},  // 16 R1 exactly F
    '{1'b0,1'b0,8'd4, 1'b1,1'b0,1'b0},  // 17
    '{1'b0,1'b1,8'd4, 1'b1,1'b0,1'b0},  // 18
    '{1'b0,1'b0,8'd6, 1'b1,1'b1,1'b0},  // 19 R1 no wake
    '{1'b0,1'b1,8'd5, 1'b0,1'b0,1'b0},  // 20 R5 supply invalid
    '{1'b0,1'b0,8'd5, 1'b0,1'b0,1'b0},  // 21
    '{1'b0,1'b1,8'd5, 1'b0,1'b0,1'b0},  // 22
    '{1'b0,1'b0,8'd6, 1'b0,1'b1,1'b1},  // 23 R5 latched, rxd high
    '{1'b0,1'b0,8'd4, 1'b1,1'b1,1'b1},  // 24 R5 rxd low once valid
    '{1'b1,1'b0,8'd6, 1'b1,1'b1,1'b0},  // 25 clear
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 26 R6 first dominant
    '{1'b0,1'b0,8'd60,1'b1,1'b0,1'b0},  // 27 window expires
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 28 only a new start
    '{1'b0,1'b0,8'd6, 1'b1,1'b1,1'b0},  // 29 R6 no wake
    '{1'b0,1'b0,8'd50,1'b1,1'b1,1'b0},  // 30 R6 expire again
    '{1'b0,1'b1,8'd60,1'b1,1'b0,1'b0},  // 31 R7 stuck dominant
    '{1'b0,1'b0,8'd2, 1'b1,1'b0,1'b0},  // 32 short
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 33 ignored while re-arming
    '{1'b0,1'b0,8'd5, 1'b1,1'b0,1'b0},  // 34 re-arm
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 35 first dominant
    '{1'b0,1'b0,8'd6, 1'b1,1'b1,1'b0},  // 36 R7 no wake yet
    '{1'b0,1'b1,8'd5, 1'b1,1'b0,1'b0},  // 37 second dominant
    '{1'b0,1'b0,8'd6, 1'b1,1'b1,1'b1},  // 38 R7 wake
    '{1'b1,1'b0,8'd6, 1'b1,1'b1,1'b0}   // 39 clear
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; len rising edges sample the level.
  task automatic seg(input logic d, input int len, input logic v, input logic c);
    bus = d;
    vio = v;
    clr = c;
    @(negedge clk);
    clr = 1'b0;
    for (int k = 1; k < len; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R5", "reset wake_req", wake_req, 1'b0);
    check("R5", "reset rxd_n", rxd_n, 1'b1);
    enable = 1'b1;

    for (int i = 0; i < NV; i++) begin
      seg(VEC[i].dom, int'(VEC[i].len), VEC[i].v, VEC[i].c);
      if (VEC[i].chk) begin
        check($sformatf("vec%0d", i), "wake_req", wake_req, VEC[i].wk);
        check($sformatf("vec%0d", i), "rxd_n", rxd_n, ~(VEC[i].wk & VEC[i].v));
      end
    end

    // R4: exact recognition edge
    seg(1'b0, 10, 1'b1, 1'b0);
    seg(1'b1, 5, 1'b1, 1'b0);
    seg(1'b0, 5, 1'b1, 1'b0);
    bus = 1'b1;
    for (int k = 0; k < F + 3; k++) @(negedge clk);
    check("R4", "wake one edge early", wake_req, 1'b0);
    @(negedge clk);
    check("R4", "wake on edge F+4", wake_req, 1'b1);
    seg(1'b0, 6, 1'b1, 1'b1);
    check("R8", "clear after R4", wake_req, 1'b0);

    // R9: pattern while disabled is ignored
    enable = 1'b0;
    seg(1'b1, 5, 1'b1, 1'b0);
    seg(1'b0, 5, 1'b1, 1'b0);
    seg(1'b1, 5, 1'b1, 1'b0);
    seg(1'b0, 6, 1'b1, 1'b0);
    check("R9", "disabled wake_req", wake_req, 1'b0);
    check("R9", "disabled rxd_n", rxd_n, 1'b1);
    enable = 1'b1;
    seg(1'b0, 8, 1'b1, 1'b0);

    // R9: disabling mid-pattern discards it
    seg(1'b1, 5, 1'b1, 1'b0);
    seg(1'b0, 5, 1'b1, 1'b0);
    enable = 1'b0;
    seg(1'b0, 3, 1'b1, 1'b0);
    enable = 1'b1;
    seg(1'b1, 5, 1'b1, 1'b0);
    seg(1'b0, 6, 1'b1, 1'b0);
    check("R9", "mid-pattern disable", wake_req, 1'b0);
    seg(1'b0, 50, 1'b1, 1'b0);

    // R8: clear abandons a partial pattern
    seg(1'b1, 5, 1'b1, 1'b0);
    seg(1'b0, 5, 1'b1, 1'b0);
    seg(1'b0, 3, 1'b1, 1'b1);
    seg(1'b1, 5, 1'b1, 1'b0);
    seg(1'b0, 6, 1'b1, 1'b0);
    check("R8", "clear mid-pattern", wake_req, 1'b0);
    check("R8", "clear mid-pattern rxd_n", rxd_n, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule